// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Slave Port

This block is the device-side end of a byte-wide parallel configuration bus. An external host supplies the configuration clock. It selects the device with an active-low select and sets the transfer direction with an active-low write strobe. In write direction, the port takes one byte per qualifying rising edge from the 8-bit bus and hands it to an internal loader as a one-cycle valid pulse. In read direction, the port takes one byte per edge from an internal readback source and drives it onto the bus. A four-state controller tracks idle, configuration, readback and a sticky aborted condition. It reports its state and the abort flag on plain status pins.

The bus is numbered in reverse of byte significance: bus pin 0 carries byte bit 7 and bus pin 7 carries byte bit 0. The mapping is the same in both directions. The loader-side stream has no ready input, because the host clocks the bus and cannot be stalled. The loader must accept a byte in every cycle where the valid flag is high. The readback source must present its byte in the same cycle in which the request is high, so that the byte is ready before the following edge.

Top module: `cfg_par_port`

## Requirements
- R1: On a rising edge where sel_n=0 and wr_n=0 and the state is IDLE or CONFIG, byte_valid is 1 in the next cycle for exactly one cycle and byte_data holds the captured byte. Otherwise byte_valid is 0.
- R2: Bus pin i corresponds to byte bit 7-i in both directions. Pins 0..3 carry the high nibble and pins 4..7 carry the low nibble.
- R3: On an edge with sel_n=1, no byte is captured, no readback byte is taken, the bus is not driven in the next cycle, and no abort occurs.
- R4: state is encoded as IDLE=0, CONFIG=1, READBACK=2, ABORTED=3. The first accepted write byte moves IDLE to CONFIG.
- R5: A done=1 edge in CONFIG (with no abort on that edge) or in READBACK returns the state to IDLE. In IDLE, done has no effect.
- R6: In CONFIG, an edge with sel_n=0 and wr_n=1 moves the state to ABORTED and raises aborted. ABORTED blocks byte_valid, readback and bus drive, and only rst leaves it.
- R7: In IDLE, an edge with sel_n=0 and wr_n=1 enters READBACK. The bus is not driven in the cycle that follows this edge.
- R8: In READBACK, rb_req is 1 in a cycle exactly when sel_n=0, wr_n=1 and done=0. On that edge rb_data is taken, and in the next cycle bus_oe=1 and bus_out holds that byte under the R2 mapping.
- R9: bus_oe falls in the cycle after the first edge where the R8 condition fails. It is never 1 after an edge on which wr_n was 0.
- R10: While rst=1 at an edge, the state becomes IDLE and byte_valid, bus_oe and aborted become 0.
- R11: Select and write strobe may fall in either order. With sel_n=1, wr_n may toggle during CONFIG without causing an abort, and a byte is accepted only on an edge where both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Device select, active low |
| wr_n | input | 1 | Direction strobe: 0 write, 1 read |
| done | input | 1 | Loader signals end of configuration or readback |
| bus_in | input | 8 | Bus pin values seen by the port |
| bus_out | output | 8 | Bus pin values driven during readback |
| bus_oe | output | 1 | Bus drive enable |
| byte_data | output | 8 | Captured byte to the loader, bit 7 = bus pin 0 |
| byte_valid | output | 1 | One-cycle flag for byte_data |
| rb_req | output | 1 | Readback source byte taken at the coming edge |
| rb_data | input | 8 | Byte from the readback source |
| state | output | 2 | Controller state code |
| aborted | output | 1 | Sticky abort status |

## Verification
The properties assume that every input is synchronous to the configuration clock. They also assume that rb_data is stable and meaningful in any cycle where rb_req is high, because the readback checks compare the driven bus with the source byte of the previous cycle. The stimulus changes inputs one time unit after each rising edge, with the select and strobe random and weighted toward writing. A done pulse is rare, and a random reset is the only way out of an abort. Directed sequences cover either order of the select and strobe, deselected toggling of the strobe, and done arriving on the same edge as an abort.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CONFIG   = 2'd1,
    ST_READBACK = 2'd2,
    ST_ABORTED  = 2'd3
  } cfgp_state_e;
endpackage

// File: rtl/cfgp_lane_map.sv
module cfgp_lane_map #(
  parameter int W = 8
) (
  input  logic [W-1:0] pins,
  output logic [W-1:0] bits
);
  // pin i carries byte bit W-1-i
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign bits[W-1-i] = pins[i];
  end
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sel_n,
  input  logic        wr_n,
  input  logic        done,
  output cfgp_state_e st,
  output logic        wr_take,
  output logic        rd_take
);
  cfgp_state_e st_nx;
  logic wr_cond, rd_cond;

  assign wr_cond = !sel_n && !wr_n;
  assign rd_cond = !sel_n && wr_n;
  assign wr_take = wr_cond && (st == ST_IDLE || st == ST_CONFIG);
  assign rd_take = rd_cond && (st == ST_READBACK) && !done;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: begin
        if (wr_cond)      st_nx = ST_CONFIG;
        else if (rd_cond) st_nx = ST_READBACK;
      end
      ST_CONFIG: begin
        if (rd_cond)      st_nx = ST_ABORTED;
        else if (done)    st_nx = ST_IDLE;
      end
      ST_READBACK: begin
        if (done)         st_nx = ST_IDLE;
      end
      default:            st_nx = ST_ABORTED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end
endmodule

// File: rtl/cfgp_wr_path.sv
module cfgp_wr_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] pins,
  output logic [W-1:0] data,
  output logic         valid
);
  logic [W-1:0] mapped;

  cfgp_lane_map #(.W(W)) u_map (.pins(pins), .bits(mapped));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= take;
      if (take) data <= mapped;
    end
  end
endmodule

// File: rtl/cfgp_rd_path.sv
module cfgp_rd_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] src,
  output logic [W-1:0] pins,
  output logic         oe
);
  logic [W-1:0] mapped;

  // mapping is its own inverse, so the same lane map serves the outbound side
  cfgp_lane_map #(.W(W)) u_map (.pins(src), .bits(mapped));

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      pins <= '0;
    end else begin
      oe <= take;
      if (take) pins <= mapped;
    end
  end
endmodule

// File: rtl/cfg_par_port.sv
module cfg_par_port
  import cfgp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_n,
  input  logic         wr_n,
  input  logic         done,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic [W-1:0] byte_data,
  output logic         byte_valid,
  output logic         rb_req,
  input  logic [W-1:0] rb_data,
  output logic [1:0]   state,
  output logic         aborted
);
  cfgp_state_e st;
  logic wr_take, rd_take;

  cfgp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .done(done),
    .st(st), .wr_take(wr_take), .rd_take(rd_take)
  );

  cfgp_wr_path #(.W(W)) u_wr (
    .clk(clk), .rst(rst), .take(wr_take), .pins(bus_in),
    .data(byte_data), .valid(byte_valid)
  );

  cfgp_rd_path #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .take(rd_take), .src(rb_data),
    .pins(bus_out), .oe(bus_oe)
  );

  assign rb_req  = rd_take;
  assign state   = st;
  assign aborted = (st == ST_ABORTED);
endmodule

// File: rtl/cfg_par_port_chk.sv
module cfg_par_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_n,
  input logic         wr_n,
  input logic         done,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic [W-1:0] byte_data,
  input logic         byte_valid,
  input logic         rb_req,
  input logic [W-1:0] rb_data,
  input logic [1:0]   state,
  input logic         aborted
);
  logic [W-1:0] in_bits, rb_bits;
  cfgp_lane_map #(.W(W)) u_in (.pins(bus_in),  .bits(in_bits));
  cfgp_lane_map #(.W(W)) u_rb (.pins(rb_data), .bits(rb_bits));

  p_valid_needs_write_r1: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(!sel_n && !wr_n));

  p_valid_data_map_r2: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> byte_data == $past(in_bits));

  p_deselect_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    $past(sel_n) |-> (!byte_valid && !bus_oe));

  p_abort_detect_r6: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1 && !sel_n && wr_n) |=> aborted);

  p_abort_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    aborted |=> aborted);

  p_abort_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    aborted |-> (!byte_valid && !rb_req));

  p_rb_data_map_r8: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> bus_out == $past(rb_bits));

  p_oe_never_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!wr_n) |-> !bus_oe);

  p_req_only_readback_r8: assert property (@(posedge clk) disable iff (rst)
    rb_req |-> (state == 2'd2 && !sel_n && wr_n && !done));
endmodule

bind cfg_par_port cfg_par_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .done(done),
  .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
  .byte_data(byte_data), .byte_valid(byte_valid), .rb_req(rb_req),
  .rb_data(rb_data), .state(state), .aborted(aborted)
);

// File: tb/cfg_par_port_test.sv
module cfg_par_port_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, sel_n, wr_n, done;
  logic [7:0] bus_in, bus_out, byte_data, rb_data;
  logic       bus_oe, byte_valid, rb_req, aborted;
  logic [1:0] state;

  cfg_par_port #(.W(8)) uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .done(done),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .byte_data(byte_data), .byte_valid(byte_valid), .rb_req(rb_req),
    .rb_data(rb_data), .state(state), .aborted(aborted)
  );

  int checks = 0;
  int errors = 0;

  // expected model
  logic [1:0] m_state;
  logic       m_valid, m_oe;
  logic [7:0] m_data, m_out;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_req(input logic [1:0] s, input logic sn, input logic wn, input logic dn);
    return (s == 2'd2) && !sn && wn && !dn;
  endfunction

  // one edge: apply inputs, check rb_req, advance model, check outputs
  task automatic step(input logic r, input logic sn, input logic wn, input logic dn,
                      input logic [7:0] b, input logic [7:0] rb);
    logic wc, rc, rq;
    rst = r; sel_n = sn; wr_n = wn; done = dn; bus_in = b; rb_data = rb;
    #1;
    rq = !r && exp_req(m_state, sn, wn, dn);
    chk("R8 rb_req", rb_req, exp_req(m_state, sn, wn, dn));
    wc = !sn && !wn;
    rc = !sn && wn;
    if (r) begin
      m_state = 2'd0; m_valid = 1'b0; m_oe = 1'b0;
    end else begin
      m_valid = wc && (m_state == 2'd0 || m_state == 2'd1);
      if (m_valid) m_data = rev8(b);
      m_oe = rq;
      if (rq) m_out = rev8(rb);
      case (m_state)
        2'd0: if (wc) m_state = 2'd1; else if (rc) m_state = 2'd2;
        2'd1: if (rc) m_state = 2'd3; else if (dn) m_state = 2'd0;
        2'd2: if (dn) m_state = 2'd0;
        default: m_state = 2'd3;
      endcase
    end
    @(posedge clk);
    #1;
    chk("R4 state", state, m_state);
    chk("R1 byte_valid", byte_valid, m_valid);
    if (m_valid) chk("R2 byte_data", byte_data, m_data);
    chk("R9 bus_oe", bus_oe, m_oe);
    if (m_oe) chk("R8 bus_out", bus_out, m_out);
    chk("R6 aborted", aborted, m_state == 2'd3);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_state = 2'd0; m_valid = 1'b0; m_oe = 1'b0; m_data = '0; m_out = '0;
    rst = 1'b1; sel_n = 1'b1; wr_n = 1'b1; done = 1'b0; bus_in = '0; rb_data = '0;

    // R10: reset state
    step(1, 1, 1, 0, 8'h00, 8'h00);
    chk("R10 reset state", {state, byte_valid, bus_oe, aborted}, 5'b0);

    // R2: pin 0 -> bit 7, single byte moves to CONFIG (R4)
    step(0, 0, 0, 0, 8'h01, 8'h00);
    chk("R2 pin0 to bit7", byte_data, 8'h80);
    chk("R4 idle to config", state, 2'd1);
    step(0, 0, 0, 0, 8'h0F, 8'h00);
    chk("R2 low pins high nibble", byte_data, 8'hF0);

    // R11/R3: deselected toggling in CONFIG is no abort
    step(0, 1, 1, 0, 8'hAA, 8'h00);
    chk("R3 deselect no byte", byte_valid, 1'b0);
    step(0, 1, 0, 0, 8'h55, 8'h00);
    chk("R11 strobe first no byte", byte_valid, 1'b0);
    step(0, 0, 0, 0, 8'h3C, 8'h00);
    chk("R11 both low byte", byte_valid, 1'b1);

    // R5: done returns to IDLE; done in IDLE has no effect
    step(0, 1, 0, 1, 8'h00, 8'h00);
    chk("R5 done to idle", state, 2'd0);
    step(0, 1, 1, 1, 8'h00, 8'h00);
    chk("R5 done idle no effect", state, 2'd0);

    // R7/R8/R9: readback entry, stream, release
    step(0, 0, 1, 0, 8'h00, 8'h12);
    chk("R7 entry no drive", bus_oe, 1'b0);
    step(0, 0, 1, 0, 8'h00, 8'h01);
    chk("R8 rb byte mapped", bus_out, 8'h80);
    step(0, 0, 1, 0, 8'h00, 8'hC3);
    step(0, 0, 0, 0, 8'hFF, 8'h77);
    chk("R9 write edge no drive", bus_oe, 1'b0);
    step(0, 0, 1, 1, 8'h00, 8'h77);
    chk("R5 readback done", state, 2'd0);

    // R6: abort wins over done, sticky until reset
    step(0, 0, 0, 0, 8'h11, 8'h00);
    step(0, 0, 1, 1, 8'h00, 8'h00);
    chk("R6 abort over done", state, 2'd3);
    step(0, 0, 0, 0, 8'h22, 8'h00);
    chk("R6 no byte after abort", byte_valid, 1'b0);
    step(0, 0, 1, 1, 8'h00, 8'h00);
    chk("R6 sticky", aborted, 1'b1);
    step(1, 1, 1, 0, 8'h00, 8'h00);
    chk("R10 reset clears abort", aborted, 1'b0);

    // random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logic r, sn, wn, dn;
      r  = ($urandom % 200) == 0;
      sn = ($urandom % 4) == 0;
      wn = (m_state == 2'd2) ? (($urandom % 8) != 0) : (($urandom % 12) == 0);
      dn = ($urandom % 40) == 0;
      step(r, sn, wn, dn, 8'($urandom), 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule